// File: doc/BRIEF.md
# Flash command sequence decoder

This block interprets bus writes aimed at a parallel NOR-style flash array. It samples the chip-enable, write-enable, address and data lines on the system clock and frames each write. The write address is captured when the later of the two enables falls. The write data is captured when the earlier of the two enables rises. Each completed write is then checked against the expected step of a command sequence. Every sequence starts with two fixed unlock writes.

When a program sequence completes, the block raises a request for one clock cycle. The request carries the target address and data for the program engine. When a chip-erase sequence completes, it raises a separate one-cycle erase request. The block drops any write that completes while the engine reports busy. Any unexpected write, and the reset command, return it to read mode without a request. Because programming can only clear bits, the array behind this block stores the old word ANDed with the new data. That merge belongs to the array and is not part of this decoder.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, prog_req and erase_req are 0 and the decoder is in read mode, so a write of data 0x10 at address 0x555 raises no request.
- R2: The program sequence has four writes: 0xAA at 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then one write with any address and data. It raises prog_req for exactly one cycle, and prog_addr and prog_data hold that last write's address and data while prog_req is high.
- R3: The chip-erase sequence has six writes: 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x10 at 0x555. It raises erase_req for exactly one cycle.
- R4: A write is active in a clock sample where both ce_n and we_n are 0. The address of a write is the value of addr at the first sample where the write is active. Address changes after that point have no effect.
- R5: The data of a write is the value of data_in at the last sample where the write is active. Data presented after either enable has returned high has no effect.
- R6: Define the end edge as the first clock edge that samples the write inactive. A request appears in the cycle after the clock edge that follows the end edge. A write is ignored entirely if busy is 1 at the edge following its end edge: no request is raised and the sequence position is unchanged.
- R7: A write whose address or command byte does not match the expected step of a sequence returns the decoder to read mode, and no request is issued.
- R8: A write with command byte 0xF0 at any address returns the decoder to read mode at every sequence step except the final program step.
- R9: At the final program step, any write completes the program, including one whose data is 0xF0.
- R10: The command byte is data_in[7:0]; the upper data bits are ignored for matching. Address matching uses only addr[10:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Bus address |
| data_in | input | DATA_W | Bus write data |
| busy | input | 1 | Embedded operation in progress |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Address for the program request |
| prog_data | output | DATA_W | Data for the program request |
| erase_req | output | 1 | One-cycle chip-erase request |

## Verification
The bench builds the block with the default widths: a 20-bit address, a 16-bit data word and an 11-bit command-address field. This leaves nine address bits above the compare field and a full upper data byte. Setting those bits in unlock writes shows that they are ignored. Directed cases stagger the two enables and change the address and data in the middle of a write, which checks which sample each latch takes. A busy window placed partway through a sequence shows that the sequence position survives ignored writes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_DATA,
        ST_ERS_SETUP,
        ST_ERS_UNL1,
        ST_ERS_UNL2
    } seq_state_e;

    localparam int unsigned CMD_BYTE_W = 8;
    localparam int unsigned KEY_AW     = 11;

    localparam logic [CMD_BYTE_W-1:0] CMD_KEY_A   = 8'hAA;
    localparam logic [CMD_BYTE_W-1:0] CMD_KEY_B   = 8'h55;
    localparam logic [CMD_BYTE_W-1:0] CMD_PROGRAM = 8'hA0;
    localparam logic [CMD_BYTE_W-1:0] CMD_ERS_SET = 8'h80;
    localparam logic [CMD_BYTE_W-1:0] CMD_ERS_ALL = 8'h10;
    localparam logic [CMD_BYTE_W-1:0] CMD_TO_READ = 8'hF0;

    localparam logic [KEY_AW-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [KEY_AW-1:0] KEY_ADDR_B = 11'h2AA;

endpackage

// File: rtl/flash_bus_framer.sv
module flash_bus_framer #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] addr_lat;
        logic [DATA_W-1:0] data_lat;
        logic              stb;
        logic [ADDR_W-1:0] stb_addr;
        logic [DATA_W-1:0] stb_data;
    } frm_t;

    frm_t frm_d, frm_q;
    logic act_now;

    always_comb begin
        act_now = !ce_n && !we_n;
        frm_d = frm_q;
        frm_d.act = act_now;
        frm_d.stb = 1'b0;
        // later of the two falling enables opens the write
        if (act_now && !frm_q.act) begin
            frm_d.addr_lat = addr;
        end
        // keep the newest data until the first enable rises
        if (act_now) begin
            frm_d.data_lat = data_in;
        end
        if (!act_now && frm_q.act) begin
            frm_d.stb      = 1'b1;
            frm_d.stb_addr = frm_q.addr_lat;
            frm_d.stb_data = frm_q.data_lat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign wr_stb  = frm_q.stb;
    assign wr_addr = frm_q.stb_addr;
    assign wr_data = frm_q.stb_data;

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CMD_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req
);

    localparam logic [CMD_AW-1:0] ADR_A = CMD_AW'(KEY_ADDR_A);
    localparam logic [CMD_AW-1:0] ADR_B = CMD_AW'(KEY_ADDR_B);

    typedef struct packed {
        seq_state_e        st;
        logic              preq;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic              ereq;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CMD_BYTE_W-1:0] cmd;
    logic [CMD_AW-1:0]     key;
    logic at_a, at_b;

    always_comb begin
        cmd  = wr_data[CMD_BYTE_W-1:0];
        key  = wr_addr[CMD_AW-1:0];
        at_a = (key == ADR_A);
        at_b = (key == ADR_B);
        seq_d = seq_q;
        seq_d.preq = 1'b0;
        seq_d.ereq = 1'b0;
        if (wr_stb && !busy) begin
            if (seq_q.st == ST_PGM_DATA) begin
                seq_d.preq  = 1'b1;
                seq_d.paddr = wr_addr;
                seq_d.pdata = wr_data;
                seq_d.st    = ST_READ;
            end else if (cmd == CMD_TO_READ) begin
                seq_d.st = ST_READ;
            end else begin
                seq_d.st = ST_READ;
                unique case (seq_q.st)
                    ST_READ:
                        if (at_a && cmd == CMD_KEY_A) seq_d.st = ST_UNL1;
                    ST_UNL1:
                        if (at_b && cmd == CMD_KEY_B) seq_d.st = ST_UNL2;
                    ST_UNL2: begin
                        if (at_a && cmd == CMD_PROGRAM) seq_d.st = ST_PGM_DATA;
                        if (at_a && cmd == CMD_ERS_SET) seq_d.st = ST_ERS_SETUP;
                    end
                    ST_ERS_SETUP:
                        if (at_a && cmd == CMD_KEY_A) seq_d.st = ST_ERS_UNL1;
                    ST_ERS_UNL1:
                        if (at_b && cmd == CMD_KEY_B) seq_d.st = ST_ERS_UNL2;
                    ST_ERS_UNL2:
                        if (at_a && cmd == CMD_ERS_ALL) seq_d.ereq = 1'b1;
                    default: seq_d.st = ST_READ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_READ, preq: 1'b0, paddr: '0, pdata: '0, ereq: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign prog_req  = seq_q.preq;
    assign prog_addr = seq_q.paddr;
    assign prog_data = seq_q.pdata;
    assign erase_req = seq_q.ereq;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CMD_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              busy,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req
);

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    flash_bus_framer #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .data_in (data_in),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    flash_seq_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CMD_AW(CMD_AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .prog_req  (prog_req),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .erase_req (erase_req)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic we_n,
    input logic busy,
    input logic prog_req,
    input logic erase_req
);

    logic bus_act;
    assign bus_act = !ce_n && !we_n;

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req && erase_req)); // R3

    AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req); // R2

    AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req); // R3

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(prog_req || erase_req)); // R6

    AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || erase_req) |-> (!$past(bus_act, 2) && $past(bus_act, 3))); // R6

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .busy      (busy),
    .prog_req  (prog_req),
    .erase_req (erase_req)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int NVEC = 29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1;
    logic we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic busy = 1'b0;
    logic prog_req, erase_req;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .data_in(data_in), .busy(busy),
        .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_req(erase_req)
    );

    // {addr, data, expect: 0 none, 1 program, 2 erase}
    localparam logic [37:0] VEC [NVEC] = '{
        {20'h00555, 16'h00AA, 2'd0},   // R2 unlock
        {20'h002AA, 16'h0055, 2'd0},
        {20'h00555, 16'h00A0, 2'd0},
        {20'h00123, 16'hBEEF, 2'd1},   // R2 program
        {20'h00555, 16'h00AA, 2'd0},   // R3 erase
        {20'h002AA, 16'h0055, 2'd0},
        {20'h00555, 16'h0080, 2'd0},
        {20'h00555, 16'h00AA, 2'd0},
        {20'h002AA, 16'h0055, 2'd0},
        {20'h00555, 16'h0010, 2'd2},
        {20'h00555, 16'h00AA, 2'd0},   // R7 bad command
        {20'h002AA, 16'h0055, 2'd0},
        {20'h00555, 16'h0033, 2'd0},
        {20'h00555, 16'h00A0, 2'd0},
        {20'h00040, 16'h1234, 2'd0},
        {20'h00555, 16'h00AA, 2'd0},   // R8 reset command
        {20'h00007, 16'h00F0, 2'd0},
        {20'h002AA, 16'h0055, 2'd0},
        {20'h00555, 16'h00A0, 2'd0},
        {20'h00044, 16'h5678, 2'd0},
        {20'h81555, 16'hFFAA, 2'd0},   // R10 upper bits ignored
        {20'h0A2AA, 16'h1255, 2'd0},
        {20'h00555, 16'h00A0, 2'd0},
        {20'h00055, 16'hF0F0, 2'd1},   // R9 F0 as program data
        {20'h00555, 16'h00AA, 2'd0},   // R8 reset during erase
        {20'h002AA, 16'h0055, 2'd0},
        {20'h00555, 16'h0080, 2'd0},
        {20'h00000, 16'h00F0, 2'd0},
        {20'h00555, 16'h0010, 2'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = a; data_in = d;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    // called right after the enables rise at a negedge
    task automatic expect_req(input int exp, input logic [AW-1:0] ea, input logic [DW-1:0] ed, input string req);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(prog_req == (exp == 1), req, prog_req, exp == 1);
        chk(erase_req == (exp == 2), req, erase_req, exp == 2);
        if (exp == 1) begin
            chk(prog_addr == ea, req, prog_addr, ea);
            chk(prog_data == ed, req, prog_data, ed);
        end
        @(negedge clk);
        chk(!prog_req && !erase_req, "R2/R3 one-cycle pulse", {prog_req, erase_req}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!prog_req && !erase_req, "R1 reset outputs", {prog_req, erase_req}, 0);
        bus_write(20'h00555, 16'h0010);
        expect_req(0, '0, '0, "R1 idle after reset");

        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i][37:18], VEC[i][17:2]);
            expect_req(int'(VEC[i][1:0]), VEC[i][37:18], VEC[i][17:2], $sformatf("vector %0d", i));
        end

        // R6: busy drops writes and keeps the sequence position
        bus_write(20'h00555, 16'h00AA); expect_req(0, '0, '0, "R6 unlock");
        bus_write(20'h002AA, 16'h0055); expect_req(0, '0, '0, "R6 unlock");
        busy = 1'b1;
        bus_write(20'h00555, 16'h0033); expect_req(0, '0, '0, "R6 busy write");
        bus_write(20'h00300, 16'hAAAA); expect_req(0, '0, '0, "R6 busy write");
        busy = 1'b0;
        bus_write(20'h00555, 16'h00A0); expect_req(0, '0, '0, "R6 resume");
        bus_write(20'h00300, 16'hC3C3); expect_req(1, 20'h00300, 16'hC3C3, "R6 program after busy");

        // R4 R5: staggered enables, address and data change mid-write
        bus_write(20'h00555, 16'h00AA); expect_req(0, '0, '0, "R4 unlock");
        bus_write(20'h002AA, 16'h0055); expect_req(0, '0, '0, "R4 unlock");
        bus_write(20'h00555, 16'h00A0); expect_req(0, '0, '0, "R4 command");
        @(negedge clk); ce_n = 1'b0; addr = 20'h00011; data_in = 16'h1111;
        @(negedge clk); we_n = 1'b0; addr = 20'h00022;
        @(negedge clk); addr = 20'h00033; data_in = 16'h2222;
        @(negedge clk); data_in = 16'h3333;
        @(negedge clk); we_n = 1'b1; data_in = 16'h4444;
        expect_req(1, 20'h00022, 16'h3333, "R4/R5 edge latching");
        ce_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule